// File: doc/BRIEF.md
# Random-Sampling Filtered L1 Controller

This controller serves single CPU references in front of a next-level memory. It keeps two places for lines: a direct-mapped main L1 and a small fully-associative filter buffer. A reference looks in L1 first and then in the filter. If both miss, the line is read from the next level. A periodic sampler then decides where the fetched line goes. Most lines land in the filter, and only the sampled reference places its line in L1. Long-lived lines are referenced many times, so they get many chances to be sampled and to move into L1. Short-lived lines seldom get that chance.

The sampler is a single counter. It advances on every reference whose line is not in L1, and it wins once every `SAMPLE_PERIOD` such references, which gives a bias of P = 1/`SAMPLE_PERIOD`. No per-line history is kept. When a filter hit wins the draw, the line moves into L1. A dirty line displaced from L1 or from the filter is written to the next level before its slot is reused. A line is one data word. One request is handled at a time.

Top module: `sfl_ctrl`

## Requirements
- R1: A reference whose line is valid in L1 is served without any next-level request and increments the L1-hit counter by one.
- R2: The sampler advances only on references that miss L1 (filter hits and full misses). Counting from reset, every `SAMPLE_PERIOD`-th such reference wins the draw; L1 hits leave the sampler unchanged.
- R3: On a miss in both structures, the line is fetched once and the miss counter increments. A winning draw places the line in L1 at index `addr % L1_SETS`. A losing draw places it in the filter slot named by a FIFO pointer, which advances by one on every filter insertion.
- R4: A filter hit that wins the draw moves the line into L1, removes it from the filter, and increments the promotion counter.
- R5: Before a line is placed in L1, a displaced L1 line that is valid and dirty is written to the next level at its own address.
- R6: Before a filter slot is overwritten, its line is written to the next level if it is valid and dirty. Clean victims are dropped without any next-level traffic.
- R7: A read returns the last value written to that address, or the next-level content if the address was never written. A write returns its own data and marks the line dirty wherever it lives.
- R8: The filter-hit counter increments on every reference that misses L1 and hits the filter.
- R9: After reset, all lines are invalid, all counters read zero, `cpu_req_ready_o` is high and no next-level request is raised.
- R10: A next-level read carries the address of the missing line. Any next-level request, once raised, holds its address, direction and data until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_valid_i | input | 1 | CPU request present |
| cpu_req_ready_o | output | 1 | Controller idle, request accepted |
| cpu_req_we_i | input | 1 | 1 = write, 0 = read |
| cpu_req_addr_i | input | ADDR_W | Line address |
| cpu_req_wdata_i | input | DATA_W | Write data |
| cpu_resp_valid_o | output | 1 | One-cycle response pulse |
| cpu_resp_rdata_o | output | DATA_W | Line data after the reference |
| mem_req_valid_o | output | 1 | Next-level request present |
| mem_req_ready_i | input | 1 | Next level accepts request |
| mem_req_we_o | output | 1 | 1 = writeback, 0 = line fetch |
| mem_req_addr_o | output | ADDR_W | Next-level line address |
| mem_req_wdata_o | output | DATA_W | Writeback data |
| mem_resp_valid_i | input | 1 | Fetch data returned |
| mem_resp_rdata_i | input | DATA_W | Fetched line data |
| stat_l1_hit_o | output | STAT_W | L1 hit count |
| stat_flt_hit_o | output | STAT_W | Filter hit count |
| stat_miss_o | output | STAT_W | Miss count |
| stat_promo_o | output | STAT_W | Promotion count |

## Verification
A directed cold sequence of four lines on distinct indices steps the sampler through one full period. It shows that only the last of them reaches L1 and that a later L1 hit does not move the sampler. Repeated reads of lines held in the filter then bring a filter hit to a winning draw, which separates promotion from ordinary filter service. A seeded random mix of reads and writes over a narrow address range forces index conflicts and dirty victims in both structures. A bench model of both structures and of the sampler predicts the class of every reference, every writeback and the final next-level memory image. The next level's accept signal stalls at random, which exercises holding the request and merging writes into fetched lines.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FETCH,
    ST_WAIT,
    ST_WB,
    ST_COMMIT
  } ctrl_state_e;
endpackage

// File: rtl/sfl_sampler.sv
module sfl_sampler #(
  parameter int PERIOD = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic draw_i,
  output logic win_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  assign win_o = draw_i && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (draw_i)  cnt_q <= win_o ? '0 : cnt_q + 1'b1;
  end

  a_r2_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < PERIOD);
  a_r2_restart_after_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_o |=> cnt_q == '0);
  a_r2_idle_without_draw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !draw_i |=> $stable(cnt_q));
endmodule

// File: rtl/sfl_l1_array.sv
module sfl_l1_array #(
  parameter int SETS   = 64,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(SETS)-1:0]  rd_idx_i,
  output logic                     rd_valid_o,
  output logic                     rd_dirty_o,
  output logic [TAG_W-1:0]         rd_tag_o,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic                     wr_en_i,
  input  logic [$clog2(SETS)-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]         wr_tag_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     wr_dirty_i
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  a_r3_written_set_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)]);
endmodule

// File: rtl/sfl_filter.sv
module sfl_filter #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         lk_addr_i,
  output logic                      hit_o,
  output logic [$clog2(LINES)-1:0]  hit_idx_o,
  output logic [DATA_W-1:0]         hit_data_o,
  output logic                      hit_dirty_o,
  input  logic                      upd_en_i,
  input  logic [$clog2(LINES)-1:0]  upd_idx_i,
  input  logic [DATA_W-1:0]         upd_data_i,
  input  logic                      inval_en_i,
  input  logic [$clog2(LINES)-1:0]  inval_idx_i,
  input  logic                      ins_en_i,
  input  logic [ADDR_W-1:0]         ins_addr_i,
  input  logic [DATA_W-1:0]         ins_data_i,
  input  logic                      ins_dirty_i,
  output logic                      vic_valid_o,
  output logic                      vic_dirty_o,
  output logic [ADDR_W-1:0]         vic_addr_o,
  output logic [DATA_W-1:0]         vic_data_o
);
  localparam int PW = $clog2(LINES);

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [ADDR_W-1:0] addr_q [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [PW-1:0]     ptr_q;
  logic [LINES-1:0]  match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (addr_q[g] == lk_addr_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < LINES; i++)
      if (match[i]) hit_idx_o = PW'(i);
  end

  assign hit_o       = |match;
  assign hit_data_o  = data_q[hit_idx_o];
  assign hit_dirty_o = dirty_q[hit_idx_o];
  assign vic_valid_o = valid_q[ptr_q];
  assign vic_dirty_o = dirty_q[ptr_q];
  assign vic_addr_o  = addr_q[ptr_q];
  assign vic_data_o  = data_q[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (upd_en_i)   dirty_q[upd_idx_i]   <= 1'b1;
      if (inval_en_i) valid_q[inval_idx_i] <= 1'b0;
      if (ins_en_i) begin
        valid_q[ptr_q] <= 1'b1;
        dirty_q[ptr_q] <= ins_dirty_i;
        ptr_q          <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (upd_en_i) data_q[upd_idx_i] <= upd_data_i;
    if (ins_en_i) begin
      addr_q[ptr_q] <= ins_addr_i;
      data_q[ptr_q] <= ins_data_i;
    end
  end

  a_r3_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  a_r3_fifo_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_en_i |=> ptr_q == $past(ptr_q) + 1'b1);
  a_r4_removed_on_promote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_en_i |=> !valid_q[$past(inval_idx_i)]);
endmodule

// File: rtl/sfl_ctrl.sv
module sfl_ctrl #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 32,
  parameter int L1_SETS       = 64,
  parameter int FLT_LINES     = 32,
  parameter int SAMPLE_PERIOD = 20,
  parameter int STAT_W        = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic              cpu_req_we_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic [DATA_W-1:0] cpu_req_wdata_i,
  output logic              cpu_resp_valid_o,
  output logic [DATA_W-1:0] cpu_resp_rdata_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_resp_valid_i,
  input  logic [DATA_W-1:0] mem_resp_rdata_i,
  output logic [STAT_W-1:0] stat_l1_hit_o,
  output logic [STAT_W-1:0] stat_flt_hit_o,
  output logic [STAT_W-1:0] stat_miss_o,
  output logic [STAT_W-1:0] stat_promo_o
);
  import sfl_pkg::*;

  localparam int IDX_W = $clog2(L1_SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int FP_W  = $clog2(FLT_LINES);

  ctrl_state_e state_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              win_q, to_l1_q, line_dirty_q;
  logic [DATA_W-1:0] line_q;
  logic [ADDR_W-1:0] vic_addr_q;
  logic [DATA_W-1:0] vic_data_q;
  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_data_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              l1_valid, l1_dirty, l1_hit, l1_vic_dirty;
  logic [TAG_W-1:0]  l1_tag;
  logic [DATA_W-1:0] l1_data;
  logic              l1_wr_en, l1_wr_dirty;
  logic [DATA_W-1:0] l1_wr_data;
  logic              f_hit, f_dirty;
  logic [FP_W-1:0]   f_idx;
  logic [DATA_W-1:0] f_data;
  logic              f_upd_en, f_inval_en, f_ins_en;
  logic              fv_valid, fv_dirty;
  logic [ADDR_W-1:0] fv_addr;
  logic [DATA_W-1:0] fv_data;
  logic              draw, win;

  assign idx          = req_addr_q[IDX_W-1:0];
  assign tag          = req_addr_q[ADDR_W-1:IDX_W];
  assign l1_hit       = l1_valid && (l1_tag == tag);
  assign l1_vic_dirty = l1_valid && l1_dirty;
  assign draw         = (state_q == ST_LOOK) && !l1_hit;

  sfl_l1_array #(.SETS(L1_SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_l1 (
    .clk_i, .rst_ni,
    .rd_idx_i(idx), .rd_valid_o(l1_valid), .rd_dirty_o(l1_dirty),
    .rd_tag_o(l1_tag), .rd_data_o(l1_data),
    .wr_en_i(l1_wr_en), .wr_idx_i(idx), .wr_tag_i(tag),
    .wr_data_i(l1_wr_data), .wr_dirty_i(l1_wr_dirty)
  );

  sfl_filter #(.LINES(FLT_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_flt (
    .clk_i, .rst_ni,
    .lk_addr_i(req_addr_q), .hit_o(f_hit), .hit_idx_o(f_idx),
    .hit_data_o(f_data), .hit_dirty_o(f_dirty),
    .upd_en_i(f_upd_en), .upd_idx_i(f_idx), .upd_data_i(req_wdata_q),
    .inval_en_i(f_inval_en), .inval_idx_i(f_idx),
    .ins_en_i(f_ins_en), .ins_addr_i(req_addr_q), .ins_data_i(line_q),
    .ins_dirty_i(line_dirty_q),
    .vic_valid_o(fv_valid), .vic_dirty_o(fv_dirty),
    .vic_addr_o(fv_addr), .vic_data_o(fv_data)
  );

  sfl_sampler #(.PERIOD(SAMPLE_PERIOD)) u_smp (
    .clk_i, .rst_ni, .draw_i(draw), .win_o(win)
  );

  // array write controls
  always_comb begin
    l1_wr_en    = 1'b0;
    f_upd_en    = 1'b0;
    f_inval_en  = 1'b0;
    f_ins_en    = 1'b0;
    l1_wr_data  = (state_q == ST_COMMIT) ? line_q : req_wdata_q;
    l1_wr_dirty = (state_q == ST_COMMIT) ? line_dirty_q : 1'b1;
    case (state_q)
      ST_LOOK: begin
        if (l1_hit) l1_wr_en = req_we_q;
        else if (f_hit) begin
          f_upd_en   = !win && req_we_q;
          f_inval_en = win;
        end
      end
      ST_COMMIT: begin
        l1_wr_en = to_l1_q;
        f_ins_en = !to_l1_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      req_we_q       <= 1'b0;
      req_addr_q     <= '0;
      req_wdata_q    <= '0;
      win_q          <= 1'b0;
      to_l1_q        <= 1'b0;
      line_q         <= '0;
      line_dirty_q   <= 1'b0;
      vic_addr_q     <= '0;
      vic_data_q     <= '0;
      resp_valid_q   <= 1'b0;
      resp_data_q    <= '0;
      stat_l1_hit_o  <= '0;
      stat_flt_hit_o <= '0;
      stat_miss_o    <= '0;
      stat_promo_o   <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (cpu_req_valid_i) begin
          req_we_q    <= cpu_req_we_i;
          req_addr_q  <= cpu_req_addr_i;
          req_wdata_q <= cpu_req_wdata_i;
          state_q     <= ST_LOOK;
        end
        ST_LOOK: begin
          if (l1_hit) begin
            stat_l1_hit_o <= stat_l1_hit_o + 1'b1;
            resp_valid_q  <= 1'b1;
            resp_data_q   <= req_we_q ? req_wdata_q : l1_data;
            state_q       <= ST_IDLE;
          end else if (f_hit) begin
            stat_flt_hit_o <= stat_flt_hit_o + 1'b1;
            if (win) begin
              stat_promo_o <= stat_promo_o + 1'b1;
              line_q       <= req_we_q ? req_wdata_q : f_data;
              line_dirty_q <= req_we_q || f_dirty;
              to_l1_q      <= 1'b1;
              vic_addr_q   <= {l1_tag, idx};
              vic_data_q   <= l1_data;
              state_q      <= l1_vic_dirty ? ST_WB : ST_COMMIT;
            end else begin
              resp_valid_q <= 1'b1;
              resp_data_q  <= req_we_q ? req_wdata_q : f_data;
              state_q      <= ST_IDLE;
            end
          end else begin
            stat_miss_o <= stat_miss_o + 1'b1;
            win_q       <= win;
            state_q     <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_resp_valid_i) begin
          line_q       <= req_we_q ? req_wdata_q : mem_resp_rdata_i;
          line_dirty_q <= req_we_q;
          to_l1_q      <= win_q;
          if (win_q) begin
            vic_addr_q <= {l1_tag, idx};
            vic_data_q <= l1_data;
            state_q    <= l1_vic_dirty ? ST_WB : ST_COMMIT;
          end else begin
            vic_addr_q <= fv_addr;
            vic_data_q <= fv_data;
            state_q    <= (fv_valid && fv_dirty) ? ST_WB : ST_COMMIT;
          end
        end
        ST_WB: if (mem_req_ready_i) state_q <= ST_COMMIT;
        ST_COMMIT: begin
          resp_valid_q <= 1'b1;
          resp_data_q  <= line_q;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready_o  = (state_q == ST_IDLE);
  assign cpu_resp_valid_o = resp_valid_q;
  assign cpu_resp_rdata_o = resp_data_q;
  assign mem_req_valid_o  = (state_q == ST_FETCH) || (state_q == ST_WB);
  assign mem_req_we_o     = (state_q == ST_WB);
  assign mem_req_addr_o   = (state_q == ST_WB) ? vic_addr_q : req_addr_q;
  assign mem_req_wdata_o  = vic_data_q;

  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_we_o) && $stable(mem_req_wdata_o));
  a_r1_l1_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOK) && l1_hit |=> !mem_req_valid_o);
  a_r9_resp_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_resp_valid_o |-> cpu_req_ready_o);
  a_r4_promo_needs_flt_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_promo_o != $past(stat_promo_o)) |-> (stat_flt_hit_o != $past(stat_flt_hit_o)));
  a_r8_single_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({stat_l1_hit_o != $past(stat_l1_hit_o), stat_flt_hit_o != $past(stat_flt_hit_o),
                stat_miss_o != $past(stat_miss_o)}) <= 1);
endmodule

// File: tb/sim_sfl_ctrl.sv
module sim_sfl_ctrl;
  localparam int AW = 8, DW = 32, SETS = 4, FL = 4, PER = 4, SW = 16;
  localparam int IW = $clog2(SETS);

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0, req_ready, resp_valid;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, resp_rdata;
  logic          mem_valid, mem_ready = 1'b0, mem_we, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic [SW-1:0] s_l1, s_fh, s_miss, s_promo;

  sfl_ctrl #(.ADDR_W(AW), .DATA_W(DW), .L1_SETS(SETS), .FLT_LINES(FL),
             .SAMPLE_PERIOD(PER), .STAT_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_valid_i(req_valid), .cpu_req_ready_o(req_ready), .cpu_req_we_i(req_we),
    .cpu_req_addr_i(req_addr), .cpu_req_wdata_i(req_wdata),
    .cpu_resp_valid_o(resp_valid), .cpu_resp_rdata_o(resp_rdata),
    .mem_req_valid_o(mem_valid), .mem_req_ready_i(mem_ready), .mem_req_we_o(mem_we),
    .mem_req_addr_o(mem_addr), .mem_req_wdata_o(mem_wdata),
    .mem_resp_valid_i(mem_rvalid), .mem_resp_rdata_i(mem_rdata),
    .stat_l1_hit_o(s_l1), .stat_flt_hit_o(s_fh), .stat_miss_o(s_miss), .stat_promo_o(s_promo)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] dut_mem [256];
  logic [DW-1:0] mmem [256];
  logic [DW-1:0] truth [256];
  // reference model
  bit            m_l1v [SETS], m_l1dirty [SETS];
  int            m_l1a [SETS];
  logic [DW-1:0] m_l1d [SETS];
  bit            m_fv [FL], m_fdirty [FL];
  int            m_fa [FL];
  logic [DW-1:0] m_fd [FL];
  int m_fptr = 0, m_cnt = 0;
  int e_l1 = 0, e_fh = 0, e_miss = 0, e_promo = 0, e_rd = 0, e_wr = 0;
  int obs_rd = 0, obs_wr = 0, rd_pend = 0, cur_addr = 0;
  logic [AW-1:0] rd_addr = '0;

  function automatic logic [DW-1:0] init_val(int a);
    return (DW'(a) * 32'h0100_0193) ^ 32'h5a5a_0f0f;
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // next-level memory: decisions at negedge take effect at the following posedge
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (rd_pend > 0) begin
      rd_pend--;
      if (rd_pend == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = dut_mem[rd_addr];
      end
    end
    mem_ready = ($urandom % 3) != 0;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        dut_mem[mem_addr] = mem_wdata;
        obs_wr++;
      end else begin
        obs_rd++;
        rd_addr = mem_addr;
        rd_pend = 2;
        check(int'(mem_addr) == cur_addr, "R10 fetch address", DW'(mem_addr), DW'(cur_addr));
      end
    end
  end

  task automatic model_l1_place(int a, logic [DW-1:0] d, bit dirty);
    int i = a % SETS;
    if (m_l1v[i] && m_l1dirty[i]) begin
      mmem[m_l1a[i]] = m_l1d[i];
      e_wr++;
    end
    m_l1v[i] = 1; m_l1a[i] = a; m_l1d[i] = d; m_l1dirty[i] = dirty;
  endtask

  task automatic model_access(bit we, int a, logic [DW-1:0] wd);
    int  i = a % SETS;
    int  j = -1;
    bit  win;
    logic [DW-1:0] d;
    if (we) truth[a] = wd;
    if (m_l1v[i] && m_l1a[i] == a) begin
      e_l1++;
      if (we) begin m_l1d[i] = wd; m_l1dirty[i] = 1; end
      return;
    end
    win   = (m_cnt == PER - 1);
    m_cnt = (m_cnt + 1) % PER;
    for (int k = 0; k < FL; k++) if (m_fv[k] && m_fa[k] == a) j = k;
    if (j >= 0) begin
      e_fh++;
      if (!win) begin
        if (we) begin m_fd[j] = wd; m_fdirty[j] = 1; end
      end else begin
        e_promo++;
        d = we ? wd : m_fd[j];
        m_fv[j] = 0;
        model_l1_place(a, d, we || m_fdirty[j]);
      end
    end else begin
      e_miss++;
      e_rd++;
      d = we ? wd : mmem[a];
      if (win) model_l1_place(a, d, we);
      else begin
        if (m_fv[m_fptr] && m_fdirty[m_fptr]) begin
          mmem[m_fa[m_fptr]] = m_fd[m_fptr];
          e_wr++;
        end
        m_fv[m_fptr] = 1; m_fa[m_fptr] = a; m_fd[m_fptr] = d; m_fdirty[m_fptr] = we;
        m_fptr = (m_fptr + 1) % FL;
      end
    end
  endtask

  task automatic access(bit we, int a, logic [DW-1:0] wd);
    model_access(we, a, wd);
    cur_addr = a;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && !done) @(negedge clk);
    check(resp_rdata == truth[a], "R7 response data", resp_rdata, truth[a]);
    check(int'(s_l1) == e_l1, "R1 L1 hit count", DW'(s_l1), DW'(e_l1));
    check(int'(s_fh) == e_fh, "R8 filter hit count", DW'(s_fh), DW'(e_fh));
    check(int'(s_miss) == e_miss, "R3 miss count", DW'(s_miss), DW'(e_miss));
    check(int'(s_promo) == e_promo, "R4 promotion count", DW'(s_promo), DW'(e_promo));
    check(obs_rd == e_rd, "R1 next-level reads", DW'(obs_rd), DW'(e_rd));
    check(obs_wr == e_wr, "R5 R6 writebacks", DW'(obs_wr), DW'(e_wr));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    void'($urandom(32'd1234));
    for (int a = 0; a < 256; a++) begin
      dut_mem[a] = init_val(a); mmem[a] = init_val(a); truth[a] = init_val(a);
    end
    for (int k = 0; k < SETS; k++) m_l1v[k] = 0;
    for (int k = 0; k < FL; k++) m_fv[k] = 0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after reset", DW'(req_ready), 1);
    check(mem_valid == 1'b0, "R9 no request in reset", DW'(mem_valid), 0);
    check((s_l1 | s_fh | s_miss | s_promo) == '0, "R9 counters zero",
          DW'(s_l1 | s_fh | s_miss | s_promo), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_valid == 1'b0 && resp_valid == 1'b0, "R9 quiet after reset",
          DW'({mem_valid, resp_valid}), 0);

    // one sampler period of cold misses, then L1 hit, then filter hits up to a promotion
    for (int a = 0; a < 4; a++) access(0, a, '0);
    access(0, 3, '0);
    check(int'(s_l1) == 1, "R2 fourth draw placed line in L1", DW'(s_l1), 1);
    access(0, 0, '0);
    access(0, 1, '0);
    access(0, 2, '0);
    check(int'(s_promo) == 0, "R2 L1 hit did not advance sampler", DW'(s_promo), 0);
    access(1, 0, 32'hdead_beef);
    check(int'(s_promo) == 1, "R4 filter hit on winning draw promoted", DW'(s_promo), 1);
    access(0, 0, '0);
    check(int'(s_l1) == 2, "R4 promoted line now hits L1", DW'(s_l1), 2);

    for (int n = 0; n < 400; n++) begin
      bit we = ($urandom % 3) == 0;
      access(we, int'($urandom % 24), $urandom);
    end

    bad = 0;
    for (int a = 0; a < 256; a++) if (dut_mem[a] !== mmem[a]) bad++;
    check(bad == 0, "R5 R6 next-level image", DW'(bad), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule